// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions. Each direction carries its own storage element. That element can run in one of three ways:

- **Transparent:** it passes the source port straight through.
- **Latched:** it keeps what it last held.
- **Clocked:** it loads the source port on the rising edge of that direction's external clock.

Which of these applies is set by two things. The first is the direction's latch enable. The second is whether its clock toggles while its active-low clock enable is asserted. Each direction also has an active-low output enable. The port drivers are modelled as a data vector plus a drive-enable output, not as real three-state pins.

The whole block runs on one fast system clock. Each direction synchronises its external clock and clock enable into that domain. An edge-tracking state machine then follows the sampled clock.

The state machine has two states, CLK_LO and CLK_HI. It makes three kinds of transition:

| Transition | From | To | Condition | Effect |
|---|---|---|---|---|
| rise | CLK_LO | CLK_HI | sample reads 1 | the only capture point |
| fall | CLK_HI | CLK_LO | sample reads 0 | no capture |
| stay | either | same state | sample unchanged | no capture |

Both input ports have bus hold. A register remembers each port's last externally driven word. When the drive flag of a port drops, that remembered word stands in for the port. A flag reports contention whenever both directions would drive at once.

Top module: `ubt_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored words and both bus-hold words to zero. With the latch enable low, both data outputs read 0 after reset. With the A-to-B latch enable high and port A undriven, b_out reads 0.
- R2: While le_ab is 1, b_out equals the effective A value in the same cycle.
- R3: While le_ab stays 0 and no rise transition occurs, b_out stays constant. A rise transition needs the sampled clock to go from 0 to 1. A held-high or falling ck_ab loads nothing.
- R4: While le_ab is 0 and ckn_en_ab is 0, a 0-to-1 change of ck_ab loads the effective A value into storage. The change must be applied before system edge N. The load happens at system edge N+1, and b_out shows the new word after that edge and not earlier.
- R5: While ckn_en_ab is 1, rising edges of ck_ab are ignored and b_out keeps its stored word.
- R6: b_out_en equals the inverse of oen_ab, and a_out_en equals the inverse of oen_ba. A 1 on an output enable leaves that direction undriven.
- R7: The B-to-A path behaves like R2 to R5, using le_ba, ck_ba, ckn_en_ba and oen_ba, with port B as source and a_out as output.
- R8: When a port's drive flag is 0, that port's effective value is the last word seen while the flag was 1. Changes on the undriven data input have no effect.
- R9: contention is 1 exactly when both a_out_en and b_out_en are 1.
- R10: Take a direction whose clock is held low. When its latch enable falls, the stored word equals the last transparent word, and it keeps that word while the source changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data sensed on port A |
| a_drv | input | 1 | 1 when port A is driven externally |
| b_in | input | 18 | Data sensed on port B |
| b_drv | input | 1 | 1 when port B is driven externally |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| ck_ab | input | 1 | A-to-B capture clock |
| ckn_en_ab | input | 1 | A-to-B clock enable, active low |
| oen_ab | input | 1 | A-to-B output enable, active low |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| ck_ba | input | 1 | B-to-A capture clock |
| ckn_en_ba | input | 1 | B-to-A clock enable, active low |
| oen_ba | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Word presented to port A |
| a_out_en | output | 1 | Drive enable for port A |
| b_out | output | 18 | Word presented to port B |
| b_out_en | output | 1 | Drive enable for port B |
| contention | output | 1 | Both directions enabled at once |

## Verification
The timing properties assume certain things about the external inputs:

- Each external capture clock and clock enable holds every level for at least two system clock cycles.
- The source data is steady across the system edge that completes a capture.
- Latch enables change only while that direction's clock is low.

The stimulus meets all of these. It changes inputs only just after a falling system edge. It holds each clock level and enable for two or more cycles. It changes source data only when no rise transition is pending.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Tracked level of a direction's synchronised capture clock
    typedef enum logic [0:0] {
        CLK_LO = 1'b0,
        CLK_HI = 1'b1
    } ck_state_e;

endpackage

// File: rtl/ubt_bus_hold.sv
module ubt_bus_hold #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             pin_drv,
    output logic [WIDTH-1:0] pin_eff
);

    logic [WIDTH-1:0] keep_q;

    // Remember the last externally driven word
    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
        end else if (pin_drv) begin
            keep_q <= pin_in;
        end
    end

    // An undriven port presents the remembered word
    always_comb begin
        pin_eff = pin_drv ? pin_in : keep_q;
    end

endmodule

// File: rtl/ubt_ctrl_sync.sv
module ubt_ctrl_sync (
    input  logic clk,
    input  logic rst,
    input  logic ck_ext,
    input  logic ckn_en_ext,
    output logic ck_s,
    output logic ckn_en_s
);

    // Clock and its enable share one sampling stage so they stay aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_s     <= 1'b0;
            ckn_en_s <= 1'b1;
        end else begin
            ck_s     <= ck_ext;
            ckn_en_s <= ckn_en_ext;
        end
    end

endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
    import ubt_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    input  logic             le,
    input  logic             ck_ext,
    input  logic             ckn_en_ext,
    output logic [WIDTH-1:0] dout
);

    logic             ck_s;
    logic             ckn_en_s;
    logic             rise;
    ck_state_e        state_q;
    ck_state_e        state_d;
    logic [WIDTH-1:0] store_q;

    ubt_ctrl_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .ck_ext     (ck_ext),
        .ckn_en_ext (ckn_en_ext),
        .ck_s       (ck_s),
        .ckn_en_s   (ckn_en_s)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CLK_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and the rise event (previous sample 0, current sample 1)
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            CLK_LO: begin
                if (ck_s) begin
                    state_d = CLK_HI;
                    rise    = 1'b1;
                end
            end
            CLK_HI: begin
                if (!ck_s) begin
                    state_d = CLK_LO;
                end
            end
            default: begin
                state_d = CLK_LO;
            end
        endcase
    end

    // Storage: transparent load while le is high, gated edge load otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (le) begin
            store_q <= src;
        end else if (rise && !ckn_en_s) begin
            store_q <= src;
        end
    end

    // Output: pass-through while transparent, stored word otherwise
    always_comb begin
        dout = le ? src : store_q;
    end

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_drv,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_drv,
    input  logic             le_ab,
    input  logic             ck_ab,
    input  logic             ckn_en_ab,
    input  logic             oen_ab,
    input  logic             le_ba,
    input  logic             ck_ba,
    input  logic             ckn_en_ba,
    input  logic             oen_ba,
    output logic [WIDTH-1:0] a_out,
    output logic             a_out_en,
    output logic [WIDTH-1:0] b_out,
    output logic             b_out_en,
    output logic             contention
);

    localparam int NDIR   = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    logic [NDIR-1:0][WIDTH-1:0] src_in;
    logic [NDIR-1:0][WIDTH-1:0] src_eff;
    logic [NDIR-1:0][WIDTH-1:0] path_out;
    logic [NDIR-1:0]            drv_v;
    logic [NDIR-1:0]            le_v;
    logic [NDIR-1:0]            ck_v;
    logic [NDIR-1:0]            en_v;
    logic [NDIR-1:0]            oen_v;

    // Index by direction: the source of A-to-B is port A, and so on
    assign src_in[DIR_AB] = a_in;
    assign src_in[DIR_BA] = b_in;
    assign drv_v = {b_drv, a_drv};
    assign le_v  = {le_ba, le_ab};
    assign ck_v  = {ck_ba, ck_ab};
    assign en_v  = {ckn_en_ba, ckn_en_ab};
    assign oen_v = {oen_ba, oen_ab};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_bus_hold #(.WIDTH(WIDTH)) u_hold (
            .clk     (clk),
            .rst     (rst),
            .pin_in  (src_in[d]),
            .pin_drv (drv_v[d]),
            .pin_eff (src_eff[d])
        );

        ubt_dir_path #(.WIDTH(WIDTH)) u_path (
            .clk        (clk),
            .rst        (rst),
            .src        (src_eff[d]),
            .le         (le_v[d]),
            .ck_ext     (ck_v[d]),
            .ckn_en_ext (en_v[d]),
            .dout       (path_out[d])
        );
    end

    assign b_out      = path_out[DIR_AB];
    assign a_out      = path_out[DIR_BA];
    assign b_out_en   = !oen_v[DIR_AB];
    assign a_out_en   = !oen_v[DIR_BA];
    assign contention = !oen_v[DIR_AB] && !oen_v[DIR_BA];

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic             a_drv,
    input logic [WIDTH-1:0] b_in,
    input logic             b_drv,
    input logic             le_ab,
    input logic             ck_ab,
    input logic             ckn_en_ab,
    input logic             le_ba,
    input logic             ck_ba,
    input logic             ckn_en_ba,
    input logic [WIDTH-1:0] a_out,
    input logic             a_out_en,
    input logic [WIDTH-1:0] b_out,
    input logic             b_out_en,
    input logic             contention
);

    assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
        (le_ab && a_drv) |-> (b_out == a_in));

    assert_steady_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!le_ab && !$past(le_ab) && !$past(ck_ab, 2) && !$past(rst))
        |-> $stable(b_out));

    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (!le_ab && !$past(le_ab) && !$past(ck_ab, 3) && $past(ck_ab, 2)
         && !$past(ckn_en_ab, 2) && $past(a_drv) && !$past(rst) && !$past(rst, 2))
        |-> (b_out == $past(a_in)));

    assert_gated_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (!le_ab && !$past(le_ab) && $past(ckn_en_ab, 2) && !$past(rst))
        |-> $stable(b_out));

    assert_ba_transparent_R7: assert property (@(posedge clk) disable iff (rst)
        (le_ba && b_drv) |-> (a_out == b_in));

    assert_ba_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (!le_ba && !$past(le_ba) && ($past(ckn_en_ba, 2) || !$past(ck_ba, 2))
         && !$past(rst))
        |-> $stable(a_out));

    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (le_ab && !a_drv && $past(a_drv) && !$past(rst))
        |-> (b_out == $past(a_in)));

    assert_contention_R9: assert property (@(posedge clk) disable iff (rst)
        contention == (a_out_en && b_out_en));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_drv      (a_drv),
    .b_in       (b_in),
    .b_drv      (b_drv),
    .le_ab      (le_ab),
    .ck_ab      (ck_ab),
    .ckn_en_ab  (ckn_en_ab),
    .le_ba      (le_ba),
    .ck_ba      (ck_ba),
    .ckn_en_ba  (ckn_en_ba),
    .a_out      (a_out),
    .a_out_en   (a_out_en),
    .b_out      (b_out),
    .b_out_en   (b_out_en),
    .contention (contention)
);

// File: tb/ubt_xcvr_tb.sv
`timescale 1ns/1ps
module ubt_xcvr_tb;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         a_drv, b_drv;
    logic         le_ab, ck_ab, ckn_en_ab, oen_ab;
    logic         le_ba, ck_ba, ckn_en_ba, oen_ba;
    logic [W-1:0] a_out, b_out;
    logic         a_out_en, b_out_en, contention;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ubt_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
        .le_ab(le_ab), .ck_ab(ck_ab), .ckn_en_ab(ckn_en_ab), .oen_ab(oen_ab),
        .le_ba(le_ba), .ck_ba(ck_ba), .ckn_en_ba(ckn_en_ba), .oen_ba(oen_ba),
        .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out), .b_out_en(b_out_en),
        .contention(contention)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // d = 0: A-to-B, d = 1: B-to-A
    task automatic drive_src(int d, logic [W-1:0] v, logic drv);
        if (d == 0) begin a_in = v; a_drv = drv; end
        else        begin b_in = v; b_drv = drv; end
    endtask

    task automatic set_ctl(int d, logic le, logic ck, logic en_n);
        if (d == 0) begin le_ab = le; ck_ab = ck; ckn_en_ab = en_n; end
        else        begin le_ba = le; ck_ba = ck; ckn_en_ba = en_n; end
    endtask

    task automatic set_oe(int d, logic oen);
        if (d == 0) oen_ab = oen; else oen_ba = oen;
    endtask

    function automatic logic [W-1:0] dir_out(int d);
        return (d == 0) ? b_out : a_out;
    endfunction

    function automatic logic dir_en(int d);
        return (d == 0) ? b_out_en : a_out_en;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = 18'h2A5A5; b_in = 18'h15A5A; a_drv = 1'b0; b_drv = 1'b0;
        le_ab = 1'b0; ck_ab = 1'b0; ckn_en_ab = 1'b1; oen_ab = 1'b1;
        le_ba = 1'b0; ck_ba = 1'b0; ckn_en_ba = 1'b1; oen_ba = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: storage cleared, outputs idle
        check("R1 b_out after reset", b_out, '0);
        check("R1 a_out after reset", a_out, '0);
        check("R1 enables after reset", {16'd0, a_out_en, b_out_en}, '0);
        // R1: bus-hold words cleared (undriven ports, transparent)
        le_ab = 1'b1; le_ba = 1'b1;
        tick();
        check("R1 A hold cleared", b_out, '0);
        check("R1 B hold cleared", a_out, '0);
        le_ab = 1'b0; le_ba = 1'b0;
        tick();

        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 6; p++) begin
                logic [W-1:0] v1, v2, v3;
                v1 = W'(p * 32'h0B5A3 + d * 32'h2AAAA + 7);
                v2 = ~v1;
                v3 = v1 ^ 18'h0F0F0;
                // R2 / R7 transparent
                set_ctl(d, 1'b1, 1'b0, 1'b1);
                drive_src(d, v1, 1'b1);
                tick();
                check(d == 0 ? "R2 transparent" : "R7 transparent", dir_out(d), v1);
                // R10 close latch with clock low
                set_ctl(d, 1'b0, 1'b0, 1'b1);
                tick();
                drive_src(d, v2, 1'b1);
                tick();
                check("R10 latch close keeps last word", dir_out(d), v1);
                // R5 gated edge ignored
                set_ctl(d, 1'b0, 1'b1, 1'b1);
                repeat (3) tick();
                check("R5 gated rise ignored", dir_out(d), v1);
                set_ctl(d, 1'b0, 1'b0, 1'b1);
                repeat (2) tick();
                check("R5 gated fall ignored", dir_out(d), v1);
                // R4 capture with latency
                set_ctl(d, 1'b0, 1'b1, 1'b0);
                tick();
                check("R4 not yet captured", dir_out(d), v1);
                tick();
                check(d == 0 ? "R4 captured" : "R7 captured", dir_out(d), v2);
                // R3 held-high clock loads nothing
                drive_src(d, v3, 1'b1);
                repeat (2) tick();
                check("R3 clock held high", dir_out(d), v2);
                set_ctl(d, 1'b0, 1'b0, 1'b0);
                repeat (2) tick();
                check("R3 falling clock", dir_out(d), v2);
                // R8 bus hold
                set_ctl(d, 1'b1, 1'b0, 1'b1);
                drive_src(d, v3, 1'b1);
                tick();
                drive_src(d, v1, 1'b0);
                tick();
                check("R8 hold after release", dir_out(d), v3);
                drive_src(d, v2, 1'b0);
                tick();
                check("R8 undriven change ignored", dir_out(d), v3);
                set_ctl(d, 1'b0, 1'b0, 1'b1);
                tick();
            end
            // R6 output enable
            set_oe(d, 1'b0);
            tick();
            check("R6 enable active", {17'd0, dir_en(d)}, 18'd1);
            set_oe(d, 1'b1);
            tick();
            check("R6 enable inactive", {17'd0, dir_en(d)}, 18'd0);
        end

        // R9 contention
        oen_ab = 1'b0; oen_ba = 1'b1;
        tick();
        check("R9 single direction", {17'd0, contention}, 18'd0);
        oen_ba = 1'b0;
        tick();
        check("R9 both directions", {17'd0, contention}, 18'd1);
        oen_ab = 1'b1;
        tick();
        check("R9 released", {17'd0, contention}, 18'd0);
        oen_ba = 1'b1;
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule